// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Edge Interrupts

This block gives software control of 32 general-purpose pins through a small word-addressed register bus. Each pin can be an input or a push-pull or open-drain output. Its pad level passes through a two-flop synchroniser, and the synchronised level is watched for edges. A detected edge sets a sticky event bit. Software clears that bit by writing a one to it. Each pin has a mask bit, and a single active-high interrupt line is raised while any event bit is set with its mask bit on.

Pins are numbered from the most significant bit. Pin n is bit `31-n` of every register and of every pad vector, so pin 0 is bit 31. All registers are 32 bits wide and are selected by byte address. Writes take effect on the clock edge at which `bus_we` is sampled. A read enable loads `bus_rdata` on that same edge, and `bus_rdata` holds its value until the next read.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, every register reads zero, `pad_oe` is all zeros, `pad_out` is all zeros and `irq` is low.
- R2: The register word is selected by address: 0x00 is direction, 0x04 is open-drain, 0x08 is data, 0x0C is event, 0x10 is mask and 0x14 is edge select. A read returns its value in `bus_rdata` one clock after `bus_re` is sampled. Any other address reads as zero, and a write to it changes nothing.
- R3: A direction bit of 1 makes the pin an output. A direction bit of 0 makes it an input, with its `pad_oe` bit low.
- R4: For an output pin with its open-drain bit clear, `pad_oe` is 1 and `pad_out` follows the data bit. For an output pin with its open-drain bit set, `pad_oe` is 1 only while the data bit is 0, and `pad_out` is 0.
- R5: A read of the data register returns, for each bit, the stored data bit if the pin is an output and the synchronised pad level if the pin is an input.
- R6: An edge-select bit of 1 latches an event on falling edges only. A bit of 0 latches an event on both edges. A pad change becomes visible in the event register on the third rising clock edge after it.
- R7: Writing 1 to an event bit clears it. Writing 0 leaves it unchanged. An event bit stays set until it is cleared.
- R8: `irq` is high exactly when some pin has both its event bit and its mask bit set.
- R9: When a new edge and a clearing write reach the same event bit on the same clock edge, the bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad levels; bit 31-n belongs to pin n |
| pad_out | output | 32 | Output values driven to the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions expect every pad to be low while reset is applied. The synchroniser flops reset to zero, so a pad that is high at reset would look like a rising edge just after reset. The bench therefore holds `pad_in` at zero through reset. After each pad change it waits at least four clocks, so that each event it predicts comes from a single settled change. The edge-versus-clear race is the only case in which the bench times a bus write against a moving pad, and it places that write on the clock edge at which the edge is latched.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int PINS = 32,
  parameter int AW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [PINS-1:0] bus_wdata,
  input  logic            bus_re,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic            irq
);
  localparam logic [2:0] W_DIR = 3'd0, W_ODR = 3'd1, W_DAT = 3'd2,
                         W_EVT = 3'd3, W_MSK = 3'd4, W_EDG = 3'd5;

  logic [PINS-1:0] dir_q, odr_q, dat_q, evt_q, msk_q, edg_q;
  logic [PINS-1:0] sync1_q, sync2_q, prev_q;
  logic [PINS-1:0] hit, clr, level;
  logic [2:0]      word;
  logic            mapped;

  assign word   = bus_addr[4:2];
  assign mapped = (bus_addr[AW-1:5] == '0) && (bus_addr[1:0] == 2'b00) && (word <= W_EDG);

  // edge sources: falls always count, rises only in both-edge mode
  assign hit   = (prev_q & ~sync2_q) | (sync2_q & ~prev_q & ~edg_q);
  assign clr   = (bus_we && mapped && word == W_EVT) ? bus_wdata : '0;
  assign level = (sync2_q & ~dir_q) | (dat_q & dir_q);

  assign pad_oe  = dir_q & ~(odr_q & dat_q);
  assign pad_out = dat_q & ~odr_q;
  assign irq     = |(evt_q & msk_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      evt_q   <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      evt_q   <= (evt_q & ~clr) | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      odr_q <= '0;
      dat_q <= '0;
      msk_q <= '0;
      edg_q <= '0;
    end else if (bus_we && mapped) begin
      case (word)
        W_DIR:   dir_q <= bus_wdata;
        W_ODR:   odr_q <= bus_wdata;
        W_DAT:   dat_q <= bus_wdata;
        W_MSK:   msk_q <= bus_wdata;
        W_EDG:   edg_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      if (!mapped) bus_rdata <= '0;
      else begin
        case (word)
          W_DIR:   bus_rdata <= dir_q;
          W_ODR:   bus_rdata <= odr_q;
          W_DAT:   bus_rdata <= level;
          W_EVT:   bus_rdata <= evt_q;
          W_MSK:   bus_rdata <= msk_q;
          W_EDG:   bus_rdata <= edg_q;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && mapped && word == W_DIR) |=> dir_q == $past(bus_wdata));

  assert_read_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && mapped && word == W_DIR) |=> bus_rdata == $past(dir_q));

  assert_evt_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && mapped && word == W_EVT) |=> (($past(evt_q) & ~evt_q) == '0));

  assert_fall_latched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(prev_q & ~sync2_q) & ~evt_q) == '0));

  assert_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (msk_q != '0) && (evt_q != '0));
endmodule

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_DIR = 8'h00, A_ODR = 8'h04, A_DAT = 8'h08,
                         A_EVT = 8'h0C, A_MSK = 8'h10, A_EDG = 8'h14;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 0, bus_re = 0;
  logic [31:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  gpio_edge_irq i_gpio_edge_irq (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] f_oe(logic [31:0] d, o, v);
    return d & ~(o & v);
  endfunction
  function automatic logic [31:0] f_out(logic [31:0] o, v);
    return v & ~o;
  endfunction
  function automatic logic [31:0] f_lvl(logic [31:0] d, v, p);
    return (p & ~d) | (v & d);
  endfunction
  function automatic logic [31:0] f_evt(logic [31:0] e, old_p, new_p, sel);
    return e | (old_p & ~new_p) | (new_p & ~old_p & ~sel);
  endfunction

  task automatic check(string req, logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1;
    @(negedge clk); bus_re = 0; d = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, dir, odr, dat, msk, sel, evt, pad;
    void'($urandom(32'd77));
    idle(3); rst_n = 1; idle(2);

    // R1 reset state
    foreach (r[i]) ;
    for (int a = 0; a < 6; a++) begin
      rd(8'(a*4), r); check("R1 reg reset", r, 32'h0);
    end
    check("R1 oe", pad_oe, 32'h0);
    check("R1 out", pad_out, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R2 unmapped read and ignored write
    wr(A_DIR, 32'h1234_5678);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h18, r); check("R2 unmapped read", r, 32'h0);
    rd(A_DIR, r); check("R2 dir after stray write", r, 32'h1234_5678);
    rd(A_MSK, r); check("R2 mask after stray write", r, 32'h0);
    wr(A_DIR, 32'h0);

    // R3/R4/R5 random configurations
    dir = 0; odr = 0; dat = 0; msk = 0; sel = 0; evt = 0; pad = 0;
    for (int k = 0; k < 30; k++) begin
      dir = $urandom; odr = (k % 3 == 0) ? 32'h0 : $urandom; dat = $urandom;
      wr(A_DIR, dir); wr(A_ODR, odr); wr(A_DAT, dat);
      idle(1);
      check("R3 R4 pad_oe", pad_oe, f_oe(dir, odr, dat));
      check("R4 pad_out", pad_out, f_out(odr, dat));
      rd(A_DAT, r); check("R5 data read", r, f_lvl(dir, dat, pad));
      rd(A_ODR, r); check("R2 odr read", r, odr);
    end

    // R6/R7/R8 random edges
    wr(A_EVT, 32'hFFFF_FFFF); evt = 0;
    for (int k = 0; k < 40; k++) begin
      logic [31:0] np;
      if (k % 8 == 0) begin sel = $urandom; wr(A_EDG, sel); end
      if (k % 5 == 0) begin msk = (k == 0) ? 32'h0 : $urandom; wr(A_MSK, msk); end
      np = $urandom;
      @(negedge clk); pad_in = np;
      idle(4);
      evt = f_evt(evt, pad, np, sel); pad = np;
      rd(A_EVT, r); check("R6 event latch", r, evt);
      check("R8 irq", {31'h0, irq}, {31'h0, |(evt & msk)});
      rd(A_DAT, r); check("R5 input level", r, f_lvl(dir, dat, pad));
      if (k % 4 == 3) begin
        logic [31:0] c;
        c = $urandom;
        wr(A_EVT, c); evt = evt & ~c;
        rd(A_EVT, r); check("R7 w1c", r, evt);
      end
    end

    // R7 writing zero keeps events
    wr(A_EVT, 32'h0);
    rd(A_EVT, r); check("R7 zero write", r, evt);

    // R6 directed: falling-only ignores a rise on pin 0 (bit 31)
    wr(A_EVT, 32'hFFFF_FFFF);
    @(negedge clk); pad_in = 32'h0; idle(4);
    wr(A_EVT, 32'hFFFF_FFFF); wr(A_EDG, 32'h8000_0000); pad = 0;
    @(negedge clk); pad_in = 32'h8000_0000; idle(4);
    rd(A_EVT, r); check("R6 rise ignored in falling mode", r, 32'h0);
    @(negedge clk); pad_in = 32'h0; idle(4);
    rd(A_EVT, r); check("R6 fall seen in falling mode", r, 32'h8000_0000);

    // R8 mask off then on
    wr(A_MSK, 32'h0); idle(1);
    check("R8 masked", {31'h0, irq}, 32'h0);
    wr(A_MSK, 32'h8000_0000); idle(1);
    check("R8 unmasked", {31'h0, irq}, 32'h1);

    // R9 edge and clear on the same edge
    wr(A_EDG, 32'h0);
    @(negedge clk); pad_in = 32'h0000_0001;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = A_EVT; bus_wdata = 32'hFFFF_FFFF; bus_we = 1;
    @(negedge clk); bus_we = 0;
    rd(A_EVT, r); check("R9 edge beats clear", r, 32'h0000_0001);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule